// File: doc/BRIEF.md
# Unified Pointer Address Converter

This block sits in front of the translation hardware and turns a 64-bit shader pointer into a 49-bit translation request. The request is one select bit plus a 48-bit virtual address. When the select bit is 0, the address goes through the GPU page tables. When it is 1, the address goes through the host (IOMMU) page tables. The per-process addressing mode comes from two configuration bits: a data-ATC enable and a 32-bit-pointer flag. A draw-type dispatch forces the 64-bit GPU-page-table mode, whatever those bits say.

Two programmable windows are checked against the pointer. Both are 64KB granular and inclusive at each end.

- A hit in the GPU-VM window folds the 40-bit GPU address space out of the non-canonical hole of the 64-bit space. The window base is subtracted from the pointer and the request is steered to the GPU tables.
- A hit in the spare window keeps the mode's default translation path but carries a different memory type.

A pointer that hits neither window uses the mode's default space and a programmable default memory type. In the 64-bit host mode, a non-canonical pointer that misses the GPU-VM window is flagged as a hole access.

The block is a single pipeline stage with a valid/ready handshake on each side. Its outputs are registered.

Top module: `ptrx_top`

## Requirements
- R1: Mode decode. With the draw input at 1, or the data-ATC bit at 0, the block runs in 64-bit GPU-VM mode and ignores the 32-bit-pointer bit. Its default space there is ATC=0. With data-ATC at 1 and draw at 0, the 32-bit-pointer bit selects 32-bit host mode (1) or 64-bit host mode (0).
- R2: In 32-bit host mode, pointer bits 63:32 are ignored. The pointer is zero-extended before every comparison and before address formation.
- R3: The window registers are used with 64KB granularity. The base is the register with bits 15:0 cleared and the limit is the register with bits 15:0 set. A pointer is inside a window when base <= pointer <= limit.
- R4: A hit in the GPU-VM window gives these outputs:
  - ATC=0;
  - address = bits 47:0 of (pointer − expanded base);
  - memory type = the GPU-VM window's type;
  - hole=0.
- R5: A pointer that hits no window (and is not a hole) gives these outputs:
  - ATC=1 in both host modes and ATC=0 in GPU-VM mode;
  - address = pointer bits 47:0;
  - memory type = the default type.
- R6: Hole handling applies in 64-bit host mode only. A pointer whose bits 63:47 are neither all zeros nor all ones, and which misses the GPU-VM window, gives these outputs:
  - hole=1;
  - ATC=0;
  - address=0;
  - memory type = the default type.
- R7: A spare-window hit, outside the GPU-VM window and not a hole, gives these outputs:
  - memory type = the spare type;
  - ATC = the mode's default;
  - address = pointer bits 47:0.

  In 32-bit host mode the spare window is never used.
- R8: Handshake and timing.
  - A request is accepted on a clock edge where the input valid and the input ready are both high.
  - The result appears with the output valid exactly one edge later.
  - The input ready equals (no result held) OR (output ready).
  - While output valid is high and output ready is low, every output holds steady.
- R9: After reset, output valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Stage can accept a request |
| inPtr | input | 64 | Shader pointer |
| cfgDataAtc | input | 1 | Process default space is host tables |
| cfgPtr32 | input | 1 | Pointers are 32 bits wide |
| isDraw | input | 1 | Request comes from a draw dispatch |
| vmBaseReg | input | 64 | GPU-VM window base register |
| vmLimitReg | input | 64 | GPU-VM window limit register |
| vmMtype | input | MT_W | GPU-VM window memory type |
| spBaseReg | input | 64 | Spare window base register |
| spLimitReg | input | 64 | Spare window limit register |
| spMtype | input | MT_W | Spare window memory type |
| dfltMtype | input | MT_W | Memory type when no window hits |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outAtc | output | 1 | 1: host tables, 0: GPU tables |
| outAddr | output | 48 | Translation virtual address |
| outMtype | output | MT_W | Memory type |
| outHole | output | 1 | Pointer fell in the non-canonical hole |

## Verification
Every result is due one clock edge after the edge that accepts its request. The bench drives a request at a falling edge and samples at the next falling edge, so exactly one rising edge separates stimulus and check. During the stall test, output ready is held low. The outputs are then sampled at two consecutive falling edges while the input changes, to confirm they stay frozen. The bench then checks that the waiting request lands one edge after ready rises, and that output valid drops one edge after that when nothing new is offered.

// File: rtl/ptrx_pkg.sv
package ptrx_pkg;
  typedef enum logic [1:0] {
    MODE_VM64  = 2'd0,
    MODE_ATC64 = 2'd1,
    MODE_ATC32 = 2'd2
  } ptrMode_e;

  typedef struct packed {
    logic load;
    logic drain;
  } ptrxStrobe_t;
endpackage

// File: rtl/ptrx_window.sv
module ptrx_window #(
  parameter int PTR_W  = 64,
  parameter int GRAN_W = 16
) (
  input  logic [PTR_W-1:0] addr,
  input  logic [PTR_W-1:0] baseReg,
  input  logic [PTR_W-1:0] limitReg,
  output logic [PTR_W-1:0] baseFull,
  output logic             hit
);
  localparam logic [PTR_W-1:0] GRAN_MASK = {{(PTR_W-GRAN_W){1'b0}}, {GRAN_W{1'b1}}};

  logic [PTR_W-1:0] limitFull;

  assign baseFull  = baseReg & ~GRAN_MASK;
  assign limitFull = limitReg | GRAN_MASK;
  assign hit       = (addr >= baseFull) && (addr <= limitFull);
endmodule

// File: rtl/ptrx_ctrl.sv
module ptrx_ctrl
  import ptrx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ptrxStrobe_t strobe
);
  logic validQ;

  assign inReady      = !validQ || outReady;
  assign strobe.load  = inValid && inReady;
  assign strobe.drain = validQ && outReady;
  assign outValid     = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (strobe.drain) begin
      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/ptrx_datapath.sv
module ptrx_datapath
  import ptrx_pkg::*;
#(
  parameter int PTR_W     = 64,
  parameter int ADDR_W    = 48,
  parameter int NARROW_W  = 32,
  parameter int GRAN_W    = 16,
  parameter int MT_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrxStrobe_t       strobe,
  input  logic [PTR_W-1:0]  inPtr,
  input  logic              cfgDataAtc,
  input  logic              cfgPtr32,
  input  logic              isDraw,
  input  logic [PTR_W-1:0]  vmBaseReg,
  input  logic [PTR_W-1:0]  vmLimitReg,
  input  logic [MT_W-1:0]   vmMtype,
  input  logic [PTR_W-1:0]  spBaseReg,
  input  logic [PTR_W-1:0]  spLimitReg,
  input  logic [MT_W-1:0]   spMtype,
  input  logic [MT_W-1:0]   dfltMtype,
  output logic              outAtc,
  output logic [ADDR_W-1:0] outAddr,
  output logic [MT_W-1:0]   outMtype,
  output logic              outHole
);
  localparam int HI_W    = PTR_W - ADDR_W + 1;
  localparam int NUM_WIN = 2;
  localparam int WIN_VM  = 0;
  localparam int WIN_SP  = 1;

  ptrMode_e          mode;
  logic [PTR_W-1:0]  effPtr;
  logic [HI_W-1:0]   hiBits;
  logic              canonical;
  logic              isHole;
  logic              dfltAtc;
  logic [PTR_W-1:0]  winBase  [NUM_WIN];
  logic [PTR_W-1:0]  winLimit [NUM_WIN];
  logic [PTR_W-1:0]  winFull  [NUM_WIN];
  logic [NUM_WIN-1:0] winHit;
  logic [ADDR_W-1:0] vmOffset;

  logic              nxtAtc;
  logic [ADDR_W-1:0] nxtAddr;
  logic [MT_W-1:0]   nxtMtype;
  logic              nxtHole;

  // Mode decode: draw dispatches and a clear data-ATC bit both force GPU-VM mode.
  always_comb begin
    if (isDraw || !cfgDataAtc) mode = MODE_VM64;
    else if (cfgPtr32)         mode = MODE_ATC32;
    else                       mode = MODE_ATC64;
  end

  assign effPtr  = (mode == MODE_ATC32) ? {{(PTR_W-NARROW_W){1'b0}}, inPtr[NARROW_W-1:0]} : inPtr;
  assign dfltAtc = (mode != MODE_VM64);

  assign hiBits    = effPtr[PTR_W-1:ADDR_W-1];
  assign canonical = (hiBits == '0) || (&hiBits);

  assign winBase[WIN_VM]  = vmBaseReg;
  assign winLimit[WIN_VM] = vmLimitReg;
  assign winBase[WIN_SP]  = spBaseReg;
  assign winLimit[WIN_SP] = spLimitReg;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ptrx_window #(
      .PTR_W (PTR_W),
      .GRAN_W(GRAN_W)
    ) u_win (
      .addr    (effPtr),
      .baseReg (winBase[w]),
      .limitReg(winLimit[w]),
      .baseFull(winFull[w]),
      .hit     (winHit[w])
    );
  end

  assign vmOffset = ADDR_W'(effPtr - winFull[WIN_VM]);
  assign isHole   = (mode == MODE_ATC64) && !canonical && !winHit[WIN_VM];

  // Result selection in priority order: GPU-VM window, hole, spare window, default.
  always_comb begin
    nxtAtc   = dfltAtc;
    nxtAddr  = effPtr[ADDR_W-1:0];
    nxtMtype = dfltMtype;
    nxtHole  = 1'b0;
    if (winHit[WIN_VM]) begin
      nxtAtc   = 1'b0;
      nxtAddr  = vmOffset;
      nxtMtype = vmMtype;
    end else if (isHole) begin
      nxtAtc   = 1'b0;
      nxtAddr  = '0;
      nxtHole  = 1'b1;
    end else if (winHit[WIN_SP] && (mode != MODE_ATC32)) begin
      nxtMtype = spMtype;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAtc   <= 1'b0;
      outAddr  <= '0;
      outMtype <= '0;
      outHole  <= 1'b0;
    end else if (strobe.load) begin
      outAtc   <= nxtAtc;
      outAddr  <= nxtAddr;
      outMtype <= nxtMtype;
      outHole  <= nxtHole;
    end
  end
endmodule

// File: rtl/ptrx_top.sv
module ptrx_top
  import ptrx_pkg::*;
#(
  parameter int MT_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [63:0]     inPtr,
  input  logic            cfgDataAtc,
  input  logic            cfgPtr32,
  input  logic            isDraw,
  input  logic [63:0]     vmBaseReg,
  input  logic [63:0]     vmLimitReg,
  input  logic [MT_W-1:0] vmMtype,
  input  logic [63:0]     spBaseReg,
  input  logic [63:0]     spLimitReg,
  input  logic [MT_W-1:0] spMtype,
  input  logic [MT_W-1:0] dfltMtype,
  output logic            outValid,
  input  logic            outReady,
  output logic            outAtc,
  output logic [47:0]     outAddr,
  output logic [MT_W-1:0] outMtype,
  output logic            outHole
);
  ptrxStrobe_t strobe;

  ptrx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  ptrx_datapath #(
    .PTR_W   (64),
    .ADDR_W  (48),
    .NARROW_W(32),
    .GRAN_W  (16),
    .MT_W    (MT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inPtr     (inPtr),
    .cfgDataAtc(cfgDataAtc),
    .cfgPtr32  (cfgPtr32),
    .isDraw    (isDraw),
    .vmBaseReg (vmBaseReg),
    .vmLimitReg(vmLimitReg),
    .vmMtype   (vmMtype),
    .spBaseReg (spBaseReg),
    .spLimitReg(spLimitReg),
    .spMtype   (spMtype),
    .dfltMtype (dfltMtype),
    .outAtc    (outAtc),
    .outAddr   (outAddr),
    .outMtype  (outMtype),
    .outHole   (outHole)
  );
endmodule

// File: rtl/ptrx_checker.sv
module ptrx_checker #(
  parameter int MT_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inReady,
  input logic            cfgDataAtc,
  input logic            cfgPtr32,
  input logic            isDraw,
  input logic            outValid,
  input logic            outReady,
  input logic            outAtc,
  input logic [47:0]     outAddr,
  input logic [MT_W-1:0] outMtype,
  input logic            outHole
);
  // R8: a result waiting on the consumer keeps every field steady
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAtc) && $stable(outAddr)
                                 && $stable(outMtype) && $stable(outHole)));

  // R8: an accepted request shows up one edge later
  a_r8_accept_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R6: a hole result carries a zero address on the GPU path
  a_r6_hole_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHole) |-> (!outAtc && (outAddr == '0)));

  // R6: holes only come from requests decoded as 64-bit host mode
  a_r6_hole_mode: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !(cfgDataAtc && !cfgPtr32 && !isDraw)) |=> !outHole);

  // R1: a draw dispatch never selects the host tables
  a_r1_draw_gpu: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && isDraw) |=> !outAtc);
endmodule

bind ptrx_top ptrx_checker #(.MT_W(MT_W)) u_ptrx_checker (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .cfgDataAtc(cfgDataAtc),
  .cfgPtr32  (cfgPtr32),
  .isDraw    (isDraw),
  .outValid  (outValid),
  .outReady  (outReady),
  .outAtc    (outAtc),
  .outAddr   (outAddr),
  .outMtype  (outMtype),
  .outHole   (outHole)
);

// File: tb/ptrx_top_bench.sv
module ptrx_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MT_W = 3;
  localparam logic [63:0] GMASK = 64'h0000_0000_0000_FFFF;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic            inReady;
  logic [63:0]     inPtr = '0;
  logic            cfgDataAtc = 1'b0;
  logic            cfgPtr32 = 1'b0;
  logic            isDraw = 1'b0;
  logic [63:0]     vmBaseReg = '0;
  logic [63:0]     vmLimitReg = '0;
  logic [MT_W-1:0] vmMtype = 3'd5;
  logic [63:0]     spBaseReg = '0;
  logic [63:0]     spLimitReg = '0;
  logic [MT_W-1:0] spMtype = 3'd2;
  logic [MT_W-1:0] dfltMtype = 3'd7;
  logic            outValid;
  logic            outReady = 1'b1;
  logic            outAtc;
  logic [47:0]     outAddr;
  logic [MT_W-1:0] outMtype;
  logic            outHole;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptrx_top #(.MT_W(MT_W)) u_ptrx_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inPtr(inPtr),
    .cfgDataAtc(cfgDataAtc), .cfgPtr32(cfgPtr32), .isDraw(isDraw),
    .vmBaseReg(vmBaseReg), .vmLimitReg(vmLimitReg), .vmMtype(vmMtype),
    .spBaseReg(spBaseReg), .spLimitReg(spLimitReg), .spMtype(spMtype),
    .dfltMtype(dfltMtype), .outValid(outValid), .outReady(outReady),
    .outAtc(outAtc), .outAddr(outAddr), .outMtype(outMtype), .outHole(outHole)
  );

  // Expected result, worked out from the requirements.
  function automatic void expectFor(input logic [63:0] p, input logic da, input logic p32,
                                    input logic dr, output logic [52:0] res, output string tag);
    logic [63:0] e, vb, vl, sb, sl, d;
    logic [16:0] hi;
    logic vm64, a32, a64, vmHit, spHit, canon, dAtc;
    vm64 = dr || !da;
    a32  = !vm64 && p32;
    a64  = !vm64 && !p32;
    e    = a32 ? {32'h0, p[31:0]} : p;
    vb = vmBaseReg & ~GMASK;  vl = vmLimitReg | GMASK;
    sb = spBaseReg & ~GMASK;  sl = spLimitReg | GMASK;
    vmHit = (e >= vb) && (e <= vl);
    spHit = (e >= sb) && (e <= sl) && !a32;
    hi    = e[63:47];
    canon = (hi == 17'h0) || (hi == 17'h1FFFF);
    dAtc  = !vm64;
    if (vmHit) begin
      d = e - vb;
      res = {1'b0, d[47:0], vmMtype, 1'b0};
      tag = "R4";
    end else if (a64 && !canon) begin
      res = {1'b0, 48'h0, dfltMtype, 1'b1};
      tag = "R6";
    end else if (spHit) begin
      res = {dAtc, e[47:0], spMtype, 1'b0};
      tag = "R7";
    end else begin
      res = {dAtc, e[47:0], dfltMtype, 1'b0};
      tag = a32 ? "R2" : (vm64 ? "R1" : "R5");
    end
  endfunction

  task automatic checkOut(input logic [52:0] exp, input string tag);
    logic [52:0] act;
    act = {outAtc, outAddr, outMtype, outHole};
    compared++;
    if (!outValid || act !== exp) begin
      mismatched++;
      $display("FAIL %s ptr=%h mode=%b%b%b valid=%b actual=%h expected=%h",
               tag, inPtr, cfgDataAtc, cfgPtr32, isDraw, outValid, act, exp);
    end
  endtask

  task automatic checkBit(input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  // One request, sampled one rising edge after it is offered.
  task automatic runOne(input logic [63:0] p, input logic da, input logic p32, input logic dr);
    logic [52:0] exp;
    string tag;
    @(negedge clk);
    inPtr = p; cfgDataAtc = da; cfgPtr32 = p32; isDraw = dr; inValid = 1'b1;
    expectFor(p, da, p32, dr, exp, tag);
    @(negedge clk);
    checkOut(exp, tag);
    inValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] pts [16];
    logic [52:0] e1, e2;
    string t1, t2;
    repeat (3) @(negedge clk);
    // R9: no result after reset
    checkBit(outValid, 1'b0, "R9 outValid after reset");
    checkBit(inReady, 1'b1, "R8 inReady when empty");
    rstN = 1'b1;

    for (int cfg = 0; cfg < 2; cfg++) begin
      logic [63:0] vb, vl, sb, sl;
      if (cfg == 0) begin
        vb = 64'h0001_0000_0000_0000; vl = 64'h0001_00FF_FFFF_FFFF;
        sb = 64'h0000_7F00_0000_0000; sl = 64'h0000_7F00_0001_FFFF;
      end else begin
        vb = 64'h0000_0000_8000_0000; vl = 64'h0000_0000_8FFF_FFFF;
        sb = 64'h0000_0000_4000_0000; sl = 64'h0000_0000_4001_FFFF;
      end
      // R3: low 16 bits of the registers carry junk that must be ignored
      vmBaseReg  = vb | 64'h1234;
      vmLimitReg = (vl & ~GMASK) | 64'h0042;
      spBaseReg  = sb | 64'hABCD;
      spLimitReg = (sl & ~GMASK) | 64'h0001;
      pts[0]  = vb - 1;  pts[1]  = vb;      pts[2]  = vb + 64'h1234;  pts[3] = vl;
      pts[4]  = vl + 1;  pts[5]  = sb - 1;  pts[6]  = sb;             pts[7] = sl;
      pts[8]  = sl + 1;  pts[9]  = 64'h0;
      pts[10] = 64'hFFFF_8000_0000_0000;
      pts[11] = 64'hFFFF_7FFF_FFFF_FFFF;
      pts[12] = 64'h0000_8000_0000_0000;
      pts[13] = 64'hDEAD_BEEF_0000_1000;
      pts[14] = {32'hABCD_0000, vb[31:0]};
      pts[15] = 64'h0000_7FFF_FFFF_FFFF;
      for (int m = 0; m < 8; m++) begin
        for (int i = 0; i < 16; i++) begin
          runOne(pts[i], m[0], m[1], m[2]);
        end
      end
    end

    // R8: back-pressure holds the result, then the queued request lands one edge later
    @(negedge clk);
    outReady = 1'b0;
    inPtr = 64'h0001_0000_0000_5000; cfgDataAtc = 1'b1; cfgPtr32 = 1'b0; isDraw = 1'b0;
    inValid = 1'b1;
    expectFor(inPtr, 1'b1, 1'b0, 1'b0, e1, t1);
    @(negedge clk);
    checkOut(e1, "R8 first result");
    checkBit(inReady, 1'b0, "R8 inReady while stalled");
    inPtr = 64'h0000_0000_0000_3000;
    expectFor(inPtr, 1'b1, 1'b0, 1'b0, e2, t2);
    @(negedge clk);
    checkOut(e1, "R8 held under stall");
    outReady = 1'b1;
    @(negedge clk);
    checkOut(e2, "R8 queued request");
    inValid = 1'b0;
    @(negedge clk);
    checkBit(outValid, 1'b0, "R8 drains when idle");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule